// File: doc/BRIEF.md
# Delta-Sigma ADC Frame Reader

This block is an SPI controller that pulls one complete conversion frame out of an external eight-slot delta-sigma converter each time the converter's active-low data-ready line falls. A single transaction carries both directions at once: the controller clocks a command word out on MOSI while the converter's response streams back on MISO. Chip select stays low for the whole frame and is raised by the controller when the last bit has been clocked.

The received frame has ten 24-bit words, each sent MSB first. The first word is a status or response word. Eight channel words follow in slot order, ch0 to ch7. The last word carries a CRC. Only seven slots carry measurements (the voltage and current of each phase line plus the neutral current), but the eighth slot must still be clocked through. The block runs a CRC-16 over the frame. When the frame checks good, it releases all eight slots at once as sign-extended 32-bit samples. When it does not, it reports the frame as corrupted and keeps the previous samples.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 0, sample_valid and crc_error are 0, and every sample output bit is 0.
- R2: A frame starts only on a falling edge of drdy_n, meaning drdy_n is sampled 1 on one clock and 0 on the next. Holding drdy_n low does not start another frame. A falling edge that arrives while a frame is in progress is ignored.
- R3: spi_cs_n goes low on the clock edge that detects the falling edge. It stays low for exactly 960 clock cycles (10 words × 24 bits × 4 clocks) and then returns high.
- R4: spi_sclk runs at the system clock divided by 4 and only while chip select is low. It idles low. Each bit starts with a rising edge, and there are exactly 240 rising edges per frame. MOSI changes at a rising edge, and MISO is sampled at the following falling edge.
- R5: The first 24 bits on MOSI are cmd_word, MSB first, captured on the clock that starts the frame. The remaining 216 bits are 0.
- R6: The received frame is, in order: one status word, channel words ch0 to ch7, and a CRC word. The CRC value sits in bits 23:8 of the CRC word, and bits 7:0 of that word are ignored.
- R7: The expected CRC uses polynomial 0x1021, an initial value of 0xFFFF, MSB-first input and no final inversion. It is computed over the 216 bits of the status word and the eight channel words.
- R8: When the received CRC matches, sample_valid pulses high for exactly one cycle, one clock after spi_cs_n rises. The sample outputs take the new frame's values in that same cycle.
- R9: When the CRC does not match, crc_error pulses with the same timing as sample_valid would, sample_valid stays low, and the sample outputs keep their previous values.
- R10: Channel k appears on samples[32k+31:32k] as its 24-bit two's-complement value sign-extended to 32 bits.
- R11: Changing cmd_word while a frame is in progress does not change the bits driven on MOSI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_n | input | 1 | Converter data-ready, low when a new conversion set is ready |
| cmd_word | input | 24 | Command word sent as the first word of each frame |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock, system clock / 4 |
| spi_mosi | output | 1 | SPI data to the converter |
| spi_miso | input | 1 | SPI data from the converter |
| samples | output | 256 | Eight sign-extended 32-bit channel samples, ch0 in the low bits |
| sample_valid | output | 1 | One-cycle pulse: new samples released after a good CRC |
| crc_error | output | 1 | One-cycle pulse: frame rejected on CRC mismatch |

## Verification
The hardest situations to reach are the frames that must be rejected or ignored, because a well-behaved converter never produces them. The bench's converter model therefore builds every frame itself and computes the CRC independently. It can then damage the CRC field, flip one data bit after the CRC has been computed, or fill the ignored low byte of the CRC word with junk. A further frame pulls drdy_n high and low again in the middle of the shift and changes cmd_word at the same moment. This shows that neither the frame timing nor the MOSI stream reacts to either change.

// File: rtl/adcfr_pkg.sv
package adcfr_pkg;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE
    } fr_state_e;

    // One MSB-first step of the CCITT CRC-16
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = {c[14:0], 1'b0};
        if (c[15] ^ b) begin
            n = n ^ CRC_POLY;
        end
        return n;
    endfunction

endpackage

// File: rtl/adcfr_crc16.sv
module adcfr_crc16
    import adcfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = CRC_INIT;
        end else if (en) begin
            crc_d = crc16_step(crc_q, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/adcfr_unpack.sv
module adcfr_unpack #(
    parameter int N_CH   = 8,
    parameter int IN_W   = 24,
    parameter int OUT_W  = 32
) (
    input  logic [N_CH*IN_W-1:0]  raw,
    output logic [N_CH*OUT_W-1:0] samples
);

    localparam int EXT_W = OUT_W - IN_W;

    for (genvar k = 0; k < N_CH; k++) begin : g_slot
        logic [IN_W-1:0] word;
        assign word = raw[k*IN_W +: IN_W];
        assign samples[k*OUT_W +: OUT_W] = {{EXT_W{word[IN_W-1]}}, word};
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcfr_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int WORD_W   = 24,
    parameter int OUT_W    = 32,
    parameter int SCLK_DIV = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   drdy_n,
    input  logic [WORD_W-1:0]      cmd_word,
    output logic                   spi_cs_n,
    output logic                   spi_sclk,
    output logic                   spi_mosi,
    input  logic                   spi_miso,
    output logic [N_CH*OUT_W-1:0]  samples,
    output logic                   sample_valid,
    output logic                   crc_error
);

    localparam int N_WORDS = N_CH + 2;
    localparam int WCNT_W  = $clog2(N_WORDS);
    localparam int BCNT_W  = $clog2(WORD_W);
    localparam int PH_W    = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int RAW_W   = N_CH * WORD_W;
    localparam int CRC_W   = 16;
    localparam logic [PH_W-1:0]   PH_RISE  = '0;
    localparam logic [PH_W-1:0]   PH_FALL  = PH_W'(SCLK_DIV / 2);
    localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(SCLK_DIV - 1);
    localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(WORD_W - 1);
    localparam logic [WCNT_W-1:0] WRD_LAST = WCNT_W'(N_WORDS - 1);
    localparam logic [WCNT_W-1:0] WRD_CRC  = WCNT_W'(N_WORDS - 1);

    typedef struct packed {
        fr_state_e           state;
        logic                drdy_prev;
        logic                cs_n;
        logic                sclk;
        logic                mosi;
        logic [PH_W-1:0]     ph;
        logic [WCNT_W-1:0]   wcnt;
        logic [BCNT_W-1:0]   bcnt;
        logic [WORD_W-1:0]   tx;
        logic [WORD_W-1:0]   rx;
        logic [RAW_W-1:0]    raw;
        logic [RAW_W-1:0]    out_raw;
        logic                valid;
        logic                err;
    } fr_regs_t;

    fr_regs_t r_d, r_q;
    logic              crc_clear;
    logic              crc_en;
    logic [CRC_W-1:0]  crc_calc;
    logic [WORD_W-1:0] rx_next;

    adcfr_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .en    (crc_en),
        .din   (spi_miso),
        .crc   (crc_calc)
    );

    always_comb begin
        r_d           = r_q;
        r_d.valid     = 1'b0;
        r_d.err       = 1'b0;
        r_d.drdy_prev = drdy_n;
        crc_clear     = 1'b0;
        crc_en        = 1'b0;
        rx_next       = {r_q.rx[WORD_W-2:0], spi_miso};

        case (r_q.state)
            ST_IDLE: begin
                if (r_q.drdy_prev && !drdy_n) begin
                    r_d.state = ST_SHIFT;
                    r_d.cs_n  = 1'b0;
                    r_d.ph    = '0;
                    r_d.wcnt  = '0;
                    r_d.bcnt  = '0;
                    r_d.tx    = cmd_word;
                    crc_clear = 1'b1;
                end
            end

            ST_SHIFT: begin
                r_d.ph = (r_q.ph == PH_LAST) ? '0 : r_q.ph + 1'b1;
                if (r_q.ph == PH_RISE) begin
                    r_d.sclk = 1'b1;
                    r_d.mosi = r_q.tx[WORD_W-1];
                    r_d.tx   = {r_q.tx[WORD_W-2:0], 1'b0};
                end
                if (r_q.ph == PH_FALL) begin
                    r_d.sclk = 1'b0;
                    r_d.rx   = rx_next;
                    crc_en   = (r_q.wcnt < WRD_CRC);
                    if (r_q.bcnt == BIT_LAST) begin
                        for (int k = 0; k < N_CH; k++) begin
                            if (r_q.wcnt == WCNT_W'(k + 1)) begin
                                r_d.raw[k*WORD_W +: WORD_W] = rx_next;
                            end
                        end
                    end
                end
                if (r_q.ph == PH_LAST) begin
                    if (r_q.bcnt == BIT_LAST) begin
                        r_d.bcnt = '0;
                        if (r_q.wcnt == WRD_LAST) begin
                            r_d.state = ST_DONE;
                            r_d.cs_n  = 1'b1;
                            r_d.mosi  = 1'b0;
                        end else begin
                            r_d.wcnt = r_q.wcnt + 1'b1;
                        end
                    end else begin
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end
                end
            end

            ST_DONE: begin
                r_d.state = ST_IDLE;
                if (r_q.rx[WORD_W-1 -: CRC_W] == crc_calc) begin
                    r_d.valid   = 1'b1;
                    r_d.out_raw = r_q.raw;
                end else begin
                    r_d.err = 1'b1;
                end
            end

            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.drdy_prev <= 1'b1;
            r_q.cs_n      <= 1'b1;
            r_q.sclk      <= 1'b0;
            r_q.mosi      <= 1'b0;
            r_q.ph        <= '0;
            r_q.wcnt      <= '0;
            r_q.bcnt      <= '0;
            r_q.tx        <= '0;
            r_q.rx        <= '0;
            r_q.raw       <= '0;
            r_q.out_raw   <= '0;
            r_q.valid     <= 1'b0;
            r_q.err       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    adcfr_unpack #(
        .N_CH  (N_CH),
        .IN_W  (WORD_W),
        .OUT_W (OUT_W)
    ) u_unpack (
        .raw     (r_q.out_raw),
        .samples (samples)
    );

    assign spi_cs_n     = r_q.cs_n;
    assign spi_sclk     = r_q.sclk;
    assign spi_mosi     = r_q.mosi;
    assign sample_valid = r_q.valid;
    assign crc_error    = r_q.err;

endmodule

// File: rtl/adcfr_checker.sv
module adcfr_checker #(
    parameter int N_CH  = 8,
    parameter int OUT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  drdy_n,
    input logic                  spi_cs_n,
    input logic                  spi_sclk,
    input logic [N_CH*OUT_W-1:0] samples,
    input logic                  sample_valid,
    input logic                  crc_error
);

    // R2: chip select only drops after drdy_n was seen high then low
    a_r2_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> ($past(drdy_n, 2) && !$past(drdy_n)));

    // R4: no SPI clock activity while deselected
    a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R4: every rising SPI clock edge lies inside a selected frame
    a_r4_rise_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> !spi_cs_n);

    // R8: a result pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R8 and R9: never both outcomes at once
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_valid && crc_error));

    // R8 and R9: the outcome comes one clock after chip select rose
    a_r8_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid || crc_error) |->
            (spi_cs_n && $past(spi_cs_n) && !$past(spi_cs_n, 2)));

    // R9: a rejected frame leaves the samples untouched
    a_r9_hold_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> $stable(samples));

endmodule

bind adc_frame_reader adcfr_checker #(
    .N_CH  (N_CH),
    .OUT_W (OUT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drdy_n       (drdy_n),
    .spi_cs_n     (spi_cs_n),
    .spi_sclk     (spi_sclk),
    .samples      (samples),
    .sample_valid (sample_valid),
    .crc_error    (crc_error)
);

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;

    localparam int N_CH       = 8;
    localparam int WORD_W     = 24;
    localparam int OUT_W      = 32;
    localparam int NBITS      = 240;
    localparam int FRAME_CLKS = 960;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drdy_n = 1'b1;
    logic [WORD_W-1:0] cmd_word = '0;
    logic spi_cs_n, spi_sclk, spi_mosi;
    logic miso_r = 1'b0;
    logic [N_CH*OUT_W-1:0] samples;
    logic sample_valid, crc_error;

    always #2 clk = ~clk;

    adc_frame_reader i_adc_frame_reader (
        .clk          (clk),
        .rst_n        (rst_n),
        .drdy_n       (drdy_n),
        .cmd_word     (cmd_word),
        .spi_cs_n     (spi_cs_n),
        .spi_sclk     (spi_sclk),
        .spi_mosi     (spi_mosi),
        .spi_miso     (miso_r),
        .samples      (samples),
        .sample_valid (sample_valid),
        .crc_error    (crc_error)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // ---------------- converter model ----------------
    logic [NBITS-1:0] frame_bits = '0;
    int miso_idx = 0;
    int rise_cnt = 0;
    int last_rise = 0;
    bit per_bad = 0;
    longint cyc = 0;
    logic [NBITS-1:0] mosi_cap = '0;

    always @(posedge clk) cyc++;

    always @(negedge spi_cs_n) begin
        miso_idx = 0;
        rise_cnt = 0;
        per_bad  = 0;
    end

    always @(posedge spi_sclk) begin
        if (miso_idx < NBITS) miso_r <= frame_bits[NBITS-1-miso_idx];
        miso_idx++;
        if (rise_cnt > 0 && (int'(cyc) - last_rise) != 4) per_bad = 1;
        last_rise = int'(cyc);
        rise_cnt++;
    end

    always @(negedge spi_sclk) mosi_cap = {mosi_cap[NBITS-2:0], spi_mosi};

    // ---------------- cycle reference model ----------------
    int  m_phase = 0;
    int  m_cnt = 0;
    bit  m_prev = 1;
    bit  m_good = 1;
    bit  e_cs = 1, e_v = 0, e_e = 0;
    int  frames_done = 0;
    bit  run_cmp = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_prev = 1;
            e_cs = 1; e_v = 0; e_e = 0;
        end else begin
            e_v = 0; e_e = 0;
            if (m_phase == 0) begin
                if (m_prev && !drdy_n) begin
                    m_phase = 1; m_cnt = 0; e_cs = 0;
                end
            end else if (m_phase == 1) begin
                m_cnt++;
                if (m_cnt == FRAME_CLKS) begin
                    e_cs = 1; m_phase = 2;
                end
            end else begin
                m_phase = 0;
                if (m_good) e_v = 1; else e_e = 1;
                frames_done++;
            end
            m_prev = drdy_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            check(spi_cs_n === e_cs, "R3", "cs_n per clock", longint'(spi_cs_n), longint'(e_cs));
            check(sample_valid === e_v, "R8", "sample_valid per clock", longint'(sample_valid), longint'(e_v));
            check(crc_error === e_e, "R9", "crc_error per clock", longint'(crc_error), longint'(e_e));
        end
    end

    // ---------------- frame construction ----------------
    function automatic logic [15:0] ref_crc(input logic [215:0] d);
        logic [15:0] c = 16'hFFFF;
        for (int i = 215; i >= 0; i--) begin
            logic fb;
            fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [31:0] sext(input logic [23:0] w);
        int v;
        v = int'({8'h00, w});
        if (v >= (1 << 23)) v = v - (1 << 24);
        return 32'(v);
    endfunction

    logic [23:0] f_cmd, f_st;
    logic [23:0] f_ch [N_CH];
    int  f_mode;
    bit  f_glitch;
    logic [31:0] exp_s [N_CH];

    task automatic run_frame(input string tag);
        logic [215:0] data;
        logic [15:0]  c;
        int start;
        data = {f_st, f_ch[0], f_ch[1], f_ch[2], f_ch[3], f_ch[4], f_ch[5], f_ch[6], f_ch[7]};
        c = ref_crc(data);
        case (f_mode)
            1:       frame_bits = {data, c ^ 16'h0100, 8'h00};
            2:       frame_bits = {data, c, 8'h00} ^ (240'd1 << 100);
            3:       frame_bits = {data, c, 8'h5A};
            default: frame_bits = {data, c, 8'h00};
        endcase
        @(negedge clk);
        cmd_word = f_cmd;
        m_good = (f_mode == 0 || f_mode == 3);
        drdy_n = 1'b1;
        repeat (3) @(negedge clk);
        start = frames_done;
        drdy_n = 1'b0;
        if (f_glitch) begin
            repeat (200) @(negedge clk);
            drdy_n = 1'b1;
            cmd_word = ~f_cmd;
            repeat (2) @(negedge clk);
            drdy_n = 1'b0;
        end
        while (frames_done == start) @(negedge clk);
        // R4: clock count and period
        check(rise_cnt == NBITS, "R4", {tag, " sclk rising edges"}, rise_cnt, NBITS);
        check(!per_bad, "R4", {tag, " sclk period 4 clocks"}, per_bad, 0);
        // R5 / R11: command then zeros on MOSI
        check(mosi_cap[239:216] == f_cmd, f_glitch ? "R11" : "R5", {tag, " mosi command word"},
              longint'(mosi_cap[239:216]), longint'(f_cmd));
        check(mosi_cap[215:0] == '0, "R5", {tag, " mosi trailing zeros"},
              longint'(mosi_cap[63:0]), 0);
        if (m_good) begin
            for (int k = 0; k < N_CH; k++) exp_s[k] = sext(f_ch[k]);
        end
        for (int k = 0; k < N_CH; k++) begin
            check(samples[k*OUT_W +: OUT_W] == exp_s[k], m_good ? "R10" : "R9",
                  {tag, $sformatf(" ch%0d sample", k)},
                  longint'(samples[k*OUT_W +: OUT_W]), longint'(exp_s[k]));
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        for (int k = 0; k < N_CH; k++) exp_s[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(spi_cs_n === 1'b1, "R1", "cs_n after reset", longint'(spi_cs_n), 1);
        check(spi_sclk === 1'b0, "R1", "sclk after reset", longint'(spi_sclk), 0);
        check(spi_mosi === 1'b0, "R1", "mosi after reset", longint'(spi_mosi), 0);
        check(sample_valid === 1'b0 && crc_error === 1'b0, "R1", "strobes after reset",
              longint'({sample_valid, crc_error}), 0);
        check(samples === '0, "R1", "samples after reset", longint'(samples[63:0]), 0);
        run_cmp = 1;

        // R2 R6 R7 R8 R10: good frame, mixed signs
        f_cmd = 24'hA5C3E1; f_st = 24'h0500FF; f_mode = 0; f_glitch = 0;
        f_ch[0] = 24'h000001; f_ch[1] = 24'hFFFFFF; f_ch[2] = 24'h123456; f_ch[3] = 24'h876543;
        f_ch[4] = 24'h7FFFFF; f_ch[5] = 24'h800000; f_ch[6] = 24'h0A0B0C; f_ch[7] = 24'hF00001;
        run_frame("good_mixed");

        // R9: damaged CRC field, samples held
        f_cmd = 24'h3C0F00; f_st = 24'h000000; f_mode = 1;
        for (int k = 0; k < N_CH; k++) f_ch[k] = 24'(24'h111111 * (k + 1));
        run_frame("bad_crc_field");

        // R7 R9: data bit flipped after CRC computed
        f_cmd = 24'h000000; f_mode = 2;
        run_frame("bad_data_bit");

        // R6: junk in ignored low byte of CRC word is accepted
        f_cmd = 24'hFFFFFF; f_st = 24'h0C0C0C; f_mode = 3;
        run_frame("crc_low_byte_ignored");

        // R2 R11: drdy edge and cmd change mid-frame are ignored
        f_cmd = 24'h5A5A5A; f_mode = 0; f_glitch = 1;
        for (int k = 0; k < N_CH; k++) f_ch[k] = 24'(24'hFFF000 - k);
        run_frame("midframe_edge");

        // R10: all zero after non-zero values
        f_glitch = 0; f_cmd = 24'h800001; f_st = 24'h000000;
        for (int k = 0; k < N_CH; k++) f_ch[k] = 24'h000000;
        run_frame("all_zero");

        // R2: drdy_n held low never restarts a frame
        drdy_n = 1'b0;
        repeat (50) @(negedge clk);
        check(spi_cs_n === 1'b1, "R2", "no frame while drdy held low", longint'(spi_cs_n), 1);
        check(rise_cnt == NBITS, "R2", "no extra sclk while drdy held low", rise_cnt, NBITS);

        run_cmp = 0;
        finish_run();
    end

endmodule